// File: doc/BRIEF.md
# DMA memory port arbiter

This block lets two DMA request streams share one 32-bit memory port. Read requests come from the transmit side, and each carries a byte address, an access size and a routing tag. Write requests come from the receive side, and each carries a byte address, an access size and data. In any cycle at most one request reaches the memory. When both sides ask in the same cycle, a single priority bit picks the winner. That bit then changes sides, so a steady conflict alternates between reads and writes.

For each access the block works out byte enables from the size and the two low address bits. For writes it moves the data onto the matching byte lanes. When the memory returns a word one cycle after a read grant, the block shifts the addressed bytes down to bit 0 and clears the bytes above the access size. It hands the result back with the tag of the request that caused it. The memory is assumed to accept a request in every cycle.

Top module: `dma_mem_port_arb`

## Requirements
- R1: While reset is held, and after it with no valid request, `mem_req`, `rd_ready`, `wr_ready` and `rsp_valid` are 0. The priority bit starts on the read side.
- R2: At most one of `rd_ready` and `wr_ready` is high in a cycle, and each is high only when its own valid is high. `mem_req` is high exactly when one of them is, and `mem_we` is high exactly when the write is granted.
- R3: A request that is valid while the other side is idle is granted in the same cycle.
- R4: A write is granted only when no read is valid or when the priority bit is on the write side. Every cycle with both valids flips the priority bit, and cycles without a conflict leave it unchanged. From reset the winners of successive conflicts are read, write, read, write.
- R5: Size codes are 2'b00 for 1 byte, 2'b01 for 2 bytes and 2'b10 for 4 bytes. `mem_be` is 4'b0001 shifted left by address bits [1:0] for 1 byte, 4'b0011 shifted left by address bits [1:0] for 2 bytes, and 4'b1111 for 4 bytes. Bits shifted past bit 3 are dropped, and `mem_be` is 0 when there is no request.
- R6: On a write grant, `mem_wdata` is `wr_data` shifted left by 8 times address bits [1:0], truncated to 32 bits. With no write grant it is 0.
- R7: `rsp_valid` is high in exactly the cycle after a read grant. In that cycle `rsp_tag` equals the `rd_tag` of the granted request.
- R8: `rsp_data` is `mem_rdata` shifted right by 8 times the granted read's address bits [1:0]. It is masked to the low 8, 16 or 32 bits for sizes 1, 2 or 4.
- R9: `mem_addr` is the byte address of the granted request, and 0 when nothing is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request granted this cycle |
| rd_addr | input | ADDR_W | Read byte address |
| rd_size | input | 2 | Read access size code |
| rd_tag | input | TAG_W | Read routing tag |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request granted this cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_size | input | 2 | Write access size code |
| wr_data | input | 32 | Write data, right-aligned |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Memory read word, one cycle after a read grant |
| rsp_valid | output | 1 | Read response present |
| rsp_tag | output | TAG_W | Tag of the answered read |
| rsp_data | output | 32 | Right-aligned, size-masked read data |

## Verification
The hardest behaviour to observe is the priority bit, because it only shows when both sides ask at once. It has to keep its value through cycles in which only one side asks. The stimulus holds both valids for back-to-back conflicts, then puts a single lone read or lone write between conflicts. It checks that the next conflict is won by the side the bit left off on. Lane handling is swept over every size and every offset: each write is read back both at its own size and offset and as a full word. Partial-lane merges and the drop of lanes past bit 3 show up in the returned data.

// File: rtl/dma_mem_port_pkg.sv
package dma_mem_port_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS  = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  // byte enables for an access of the given size at the given lane offset
  function automatic logic [WORD_BYTES-1:0] lane_enables(logic [1:0] size, logic [1:0] off);
    case (size)
      SZ_BYTE: lane_enables = 4'b0001 << off;
      SZ_HALF: lane_enables = 4'b0011 << off;
      default: lane_enables = 4'b1111;
    endcase
  endfunction

  // mask keeping the low bytes of an access of the given size
  function automatic logic [WORD_BITS-1:0] size_mask(logic [1:0] size);
    case (size)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_grant,
  output logic wr_grant,
  output logic conflict,
  output logic prio_wr
);
  assign conflict = rd_req && wr_req;
  assign wr_grant = wr_req && (!rd_req || prio_wr);
  assign rd_grant = rd_req && (!wr_req || !prio_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prio_wr <= 1'b0;
    else if (conflict) prio_wr <= !prio_wr;
  end
endmodule

// File: rtl/dma_wr_steer.sv
module dma_wr_steer
  import dma_mem_port_pkg::*;
(
  input  logic [1:0]           size,
  input  logic [1:0]           off,
  input  logic [WORD_BITS-1:0] data_in,
  output logic [WORD_BYTES-1:0] be,
  output logic [WORD_BITS-1:0] data_out
);
  assign be       = lane_enables(size, off);
  assign data_out = data_in << {off, 3'b000};
endmodule

// File: rtl/dma_rd_align.sv
module dma_rd_align
  import dma_mem_port_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [1:0]           size_in,
  input  logic [1:0]           off_in,
  input  logic [TAG_W-1:0]     tag_in,
  input  logic [WORD_BITS-1:0] mem_rdata,
  output logic                 rsp_valid,
  output logic [TAG_W-1:0]     rsp_tag,
  output logic [WORD_BITS-1:0] rsp_data
);
  logic [1:0] size_q;
  logic [1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      size_q    <= SZ_BYTE;
      off_q     <= 2'b00;
    end else begin
      rsp_valid <= capture;
      if (capture) begin
        rsp_tag <= tag_in;
        size_q  <= size_in;
        off_q   <= off_in;
      end
    end
  end

  assign rsp_data = (mem_rdata >> {off_q, 3'b000}) & size_mask(size_q);
endmodule

// File: rtl/dma_mem_port_arb.sv
module dma_mem_port_arb
  import dma_mem_port_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [1:0]            rd_size,
  input  logic [TAG_W-1:0]      rd_tag,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [1:0]            wr_size,
  input  logic [WORD_BITS-1:0]  wr_data,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [WORD_BYTES-1:0] mem_be,
  output logic [WORD_BITS-1:0]  mem_wdata,
  input  logic [WORD_BITS-1:0]  mem_rdata,
  output logic                  rsp_valid,
  output logic [TAG_W-1:0]      rsp_tag,
  output logic [WORD_BITS-1:0]  rsp_data
);
  logic rd_grant, wr_grant, conflict, prio_wr;
  logic [1:0] sel_size, sel_off;
  logic [WORD_BITS-1:0] sel_data, steered;
  logic [WORD_BYTES-1:0] be_raw;

  dma_prio_arb u_arb (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_valid), .wr_req(wr_valid),
    .rd_grant(rd_grant), .wr_grant(wr_grant), .conflict(conflict), .prio_wr(prio_wr)
  );

  assign sel_size = wr_grant ? wr_size : rd_size;
  assign sel_off  = wr_grant ? wr_addr[1:0] : rd_addr[1:0];
  assign sel_data = wr_grant ? wr_data : '0;

  dma_wr_steer u_steer (
    .size(sel_size), .off(sel_off), .data_in(sel_data), .be(be_raw), .data_out(steered)
  );

  dma_rd_align #(.TAG_W(TAG_W)) u_align (
    .clk(clk), .rst_n(rst_n), .capture(rd_grant), .size_in(rd_size),
    .off_in(rd_addr[1:0]), .tag_in(rd_tag), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  assign rd_ready  = rd_grant;
  assign wr_ready  = wr_grant;
  assign mem_req   = rd_grant || wr_grant;
  assign mem_we    = wr_grant;
  assign mem_addr  = wr_grant ? wr_addr : (rd_grant ? rd_addr : '0);
  assign mem_be    = mem_req ? be_raw : '0;
  assign mem_wdata = steered;
endmodule

// File: rtl/dma_mem_port_arb_chk.sv
module dma_mem_port_arb_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [TAG_W-1:0] rd_tag,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic [3:0]       mem_be,
  input logic             rsp_valid,
  input logic [TAG_W-1:0] rsp_tag,
  input logic             conflict,
  input logic             prio_wr
);
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && wr_ready));
  assert_grant_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ready || rd_valid) && (!wr_ready || wr_valid));
  assert_we_is_write_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_req && wr_ready));
  assert_lone_read_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !wr_valid) |-> rd_ready);
  assert_write_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!rd_valid || prio_wr));
  assert_prio_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> (prio_wr != $past(prio_wr)));
  assert_prio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |=> $stable(prio_wr));
  assert_be_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != 4'b0000));
  assert_rsp_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (rsp_valid && rsp_tag == $past(rd_tag)));
  assert_no_stray_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rsp_valid);
endmodule

bind dma_mem_port_arb dma_mem_port_arb_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tag(rd_tag),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .mem_req(mem_req), .mem_we(mem_we),
  .mem_be(mem_be), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
  .conflict(conflict), .prio_wr(prio_wr)
);

// File: tb/dma_mem_port_arb_test.sv
`timescale 1ns/1ps
module dma_mem_port_arb_test;
  localparam int AW = 32;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 0, wr_valid = 0;
  logic rd_ready, wr_ready;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [1:0] rd_size = '0, wr_size = '0;
  logic [TW-1:0] rd_tag = '0;
  logic [31:0] wr_data = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  logic [TW-1:0] tag_ctr = '0;

  always #4 clk = ~clk;

  dma_mem_port_arb #(.ADDR_W(AW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_tag(rd_tag), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[5:2]];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input int off);
    logic [3:0] b = '0;
    int n = nbytes(sz);
    if (n == 4) return 4'hF;
    for (int k = 0; k < 4; k++) b[k] = (k >= off) && (k < off + n);
    return b;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] word, input logic [1:0] sz, input int off);
    logic [31:0] r = '0;
    for (int j = 0; j < nbytes(sz); j++)
      if (off + j < 4) r[8*j +: 8] = word[8*(off+j) +: 8];
    return r;
  endfunction

  task automatic do_write(input int w, input int off, input logic [1:0] sz, input logic [31:0] d);
    logic [3:0] be;
    logic [31:0] wd;
    @(negedge clk);
    wr_valid = 1; wr_addr = 32'(w * 4 + off); wr_size = sz; wr_data = d;
    #1;
    be = exp_be(sz, off);
    wd = d << (8 * off);
    chk("R3", "wr_ready", {31'b0, wr_ready}, 32'd1);
    chk("R2", "mem_we", {31'b0, mem_we}, 32'd1);
    chk("R9", "mem_addr", mem_addr, 32'(w * 4 + off));
    chk("R5", "mem_be", {28'b0, mem_be}, {28'b0, be});
    chk("R6", "mem_wdata", mem_wdata, wd);
    for (int k = 0; k < 4; k++) if (be[k]) shadow[w][8*k +: 8] = wd[8*k +: 8];
    @(posedge clk); #1;
    chk("R7", "rsp_valid after write", {31'b0, rsp_valid}, 32'd0);
    wr_valid = 0;
  endtask

  task automatic do_read(input int w, input int off, input logic [1:0] sz);
    logic [TW-1:0] t;
    @(negedge clk);
    t = tag_ctr; tag_ctr = tag_ctr + 1'b1;
    rd_valid = 1; rd_addr = 32'(w * 4 + off); rd_size = sz; rd_tag = t;
    #1;
    chk("R3", "rd_ready", {31'b0, rd_ready}, 32'd1);
    chk("R2", "mem_we on read", {31'b0, mem_we}, 32'd0);
    chk("R9", "mem_addr", mem_addr, 32'(w * 4 + off));
    chk("R5", "mem_be read", {28'b0, mem_be}, {28'b0, exp_be(sz, off)});
    @(posedge clk); #1;
    rd_valid = 0;
    chk("R7", "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk("R7", "rsp_tag", {28'b0, rsp_tag}, {28'b0, t});
    chk("R8", "rsp_data", rsp_data, exp_rd(shadow[w], sz, off));
  endtask

  task automatic do_conflict(input bit expect_rd);
    logic [TW-1:0] t;
    logic [31:0] d;
    @(negedge clk);
    t = tag_ctr; tag_ctr = tag_ctr + 1'b1;
    d = 32'h5EED_0000 | {24'b0, 4'b0, t};
    rd_valid = 1; rd_addr = 32'd4; rd_size = 2'b10; rd_tag = t;
    wr_valid = 1; wr_addr = 32'd8; wr_size = 2'b10; wr_data = d;
    #1;
    chk("R4", "rd_ready in conflict", {31'b0, rd_ready}, {31'b0, expect_rd});
    chk("R4", "wr_ready in conflict", {31'b0, wr_ready}, {31'b0, !expect_rd});
    chk("R2", "mem_req in conflict", {31'b0, mem_req}, 32'd1);
    if (!expect_rd) shadow[2] = d;
    @(posedge clk); #1;
    rd_valid = 0; wr_valid = 0;
    chk("R7", "rsp_valid after conflict", {31'b0, rsp_valid}, {31'b0, expect_rd});
    if (expect_rd) chk("R8", "rsp_data after conflict", rsp_data, shadow[1]);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'(i) * 32'h0101_0101 ^ 32'hA5C3_0F96;
      shadow[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
    chk("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "mem_req idle", {31'b0, mem_req}, 32'd0);
    chk("R1", "ready idle", {30'b0, rd_ready, wr_ready}, 32'd0);
    chk("R1", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
    chk("R9", "mem_addr idle", mem_addr, 32'd0);
    chk("R6", "mem_wdata idle", mem_wdata, 32'd0);

    // priority from reset and across lone cycles
    do_conflict(1'b1);
    do_conflict(1'b0);
    do_conflict(1'b1);
    do_read(3, 0, 2'b10);
    do_conflict(1'b0);
    do_write(4, 1, 2'b00, 32'h0000_0077);
    do_conflict(1'b1);
    do_conflict(1'b0);

    // lane sweep over every size and offset
    for (int sz = 0; sz < 3; sz++) begin
      for (int off = 0; off < 4; off++) begin
        int w = 4 + sz * 4 + off;
        logic [31:0] d = 32'h8F3A_61D4 + 32'(sz) * 32'h0123_4567 + 32'(off) * 32'h1010_1010;
        do_write(w % 16, off, 2'(sz), d);
        do_read(w % 16, off, 2'(sz));
        do_read(w % 16, 0, 2'b10);
        for (int o2 = 0; o2 < 4; o2++) do_read(w % 16, o2, 2'(sz));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule